// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block lets software fetch the contents of a one-time-programmable fuse array in bursts of up to 32 bytes. Software first programs two read-timing counts in the configuration word. It then writes a control word that carries the starting byte address, the burst length minus one and a read-enable bit. The controller then drives the fuse macro: a halfword address, and a read strobe whose setup and pulse width come from the two counts. Each 16-bit result is packed into eight 32-bit data words. When the last halfword has been captured, a done flag is raised and read-enable clears itself.

The array holds 1024 bytes, which is 512 halfwords on a 9-bit address. Fields for fuse programming, write timing and interrupt enable are stored and read back, but they have no effect.

Top module: `efuse_rd_seq`

## Requirements
- R1: After reset, every register reads zero, `fuse_strobe` is low and `fuse_addr` is zero.
- R2: The register index is `bus_addr[5:2]`. Index 0 is control, 1 is configuration, 2 is status and 3..10 are data words 0..7. Indices 11..15 read as zero. Control keeps only bits 30:15, 1 and 0, so writing all ones reads back 0x7FFF8003. Configuration keeps only bit 31 and bits 23:0, so writing all ones reads back 0x80FFFFFF. Status bit 1 always reads zero.
- R3: While idle, a control write with bit 0 set starts a burst. In the same edge it clears status bit 0 and zeroes all data words. Control bit 0 reads 1 while the burst runs.
- R4: Each access begins with adj+1 cycles with `fuse_strobe` low and the address already valid. adj is configuration bits 23:20.
- R5: `fuse_strobe` then stays high for str+4 cycles, where str is configuration bits 19:16. One access therefore takes adj+5+str cycles, and the address is held while the strobe is high.
- R6: The first access uses halfword address = start byte (control bits 30:21) with its bit 0 dropped. Each later access uses the next address, and address 511 is followed by 0.
- R7: A burst makes len/2+1 accesses, where len is control bits 20:16. Access j writes its low byte to burst byte 2j and its high byte to burst byte 2j+1. Byte k goes to data word k/4 at bits 8*(k%4)+7 : 8*(k%4). Bytes beyond len stay zero.
- R8: The edge that captures the last halfword sets status bit 0 and clears control bit 0. The other control fields are kept.
- R9: A control write while a burst is active has no effect, including a write that lands on the completing edge. Writes to status and data words have no effect.
- R10: Control bits 15 and 1, and the configuration fields other than the two read counts, have no effect. A control write with bit 0 clear starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fuse_addr | output | 9 | Halfword address to the fuse macro |
| fuse_strobe | output | 1 | Read strobe to the fuse macro |
| fuse_rdata | input | 16 | Halfword returned by the fuse macro |

## Verification
Two events can fall in the same cycle: the sequencer's final capture, which sets done and clears read-enable, and a new software control write that tries to restart. The bench waits until its model has exactly one strobe cycle left, then lands a start command with a different address on the completing edge. The write must be dropped: no further strobe appears, and the control word afterwards shows the old burst's fields with read-enable cleared. Strobe and address are compared on every clock against a schedule the bench builds from the programmed counts.

// File: rtl/efr_pkg.sv
`timescale 1ns/1ps
package efr_pkg;
  localparam int REG_W      = 32;
  localparam int IDX_CTRL   = 0;
  localparam int IDX_CFG    = 1;
  localparam int IDX_STAT   = 2;
  localparam int IDX_DATA0  = 3;
  localparam int CTL_RD     = 0;
  localparam int CTL_LEN_LSB = 16;
  localparam int CTL_ADR_LSB = 21;
  localparam int CFG_ADJ_LSB = 20;
  localparam int CFG_STR_LSB = 16;
  localparam logic [REG_W-1:0] CTL_KEEP = 32'h7FFF_8003;
  localparam logic [REG_W-1:0] CFG_KEEP = 32'h80FF_FFFF;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_STRB} sq_state_t;
endpackage

// File: rtl/efr_seq.sv
`timescale 1ns/1ps
module efr_seq import efr_pkg::*; #(
  parameter int FA_W  = 9,
  parameter int FD_W  = 16,
  parameter int LEN_W = 5,
  parameter int TIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [FA_W-1:0]  start_haddr_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic [TIM_W-1:0] adj_i,
  input  logic [TIM_W-1:0] str_i,
  input  logic [FD_W-1:0]  fuse_rdata_i,
  output logic [FA_W-1:0]  fuse_addr_o,
  output logic             fuse_strobe_o,
  output logic             busy_o,
  output logic             cap_valid_o,
  output logic [LEN_W-2:0] cap_idx_o,
  output logic [FD_W-1:0]  cap_data_o,
  output logic             finish_o
);
  localparam int CNT_W = TIM_W + 1;
  localparam int IDX_W = LEN_W - 1;

  sq_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FA_W-1:0]  addr_q, addr_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [TIM_W-1:0] adj_q, adj_d, str_q, str_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    last_d  = last_q;
    adj_d   = adj_q;
    str_d   = str_q;
    case (state_q)
      SQ_IDLE: if (start_i) begin
        state_d = SQ_SETUP;
        cnt_d   = CNT_W'(adj_i);
        addr_d  = start_haddr_i;
        idx_d   = '0;
        last_d  = start_len_i[LEN_W-1:1];
        adj_d   = adj_i;
        str_d   = str_i;
      end
      SQ_SETUP: begin
        if (cnt_zero) begin
          state_d = SQ_STRB;
          cnt_d   = CNT_W'(str_q) + CNT_W'(3);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SQ_STRB: begin
        if (cnt_zero) begin
          if (idx_q == last_q) begin
            state_d = SQ_IDLE;
          end else begin
            state_d = SQ_SETUP;
            cnt_d   = CNT_W'(adj_q);
            addr_d  = addr_q + FA_W'(1);
            idx_d   = idx_q + IDX_W'(1);
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      adj_q   <= '0;
      str_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      adj_q   <= adj_d;
      str_q   <= str_d;
    end
  end

  assign fuse_addr_o   = addr_q;
  assign fuse_strobe_o = (state_q == SQ_STRB);
  assign busy_o        = (state_q != SQ_IDLE);
  assign cap_valid_o   = fuse_strobe_o && cnt_zero;
  assign cap_idx_o     = idx_q;
  assign cap_data_o    = fuse_rdata_i;
  assign finish_o      = cap_valid_o && (idx_q == last_q);

  // R5
  strobe_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe_o && $past(fuse_strobe_o)) |-> $stable(fuse_addr_o));
  // R4
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !fuse_strobe_o);
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fuse_strobe_o) && busy_o) |-> (fuse_addr_o == $past(fuse_addr_o) + FA_W'(1)));
endmodule

// File: rtl/efr_regs.sv
`timescale 1ns/1ps
module efr_regs import efr_pkg::*; #(
  parameter int BUS_AW = 6,
  parameter int FA_W   = 9,
  parameter int FD_W   = 16,
  parameter int LEN_W  = 5,
  parameter int TIM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              busy_i,
  input  logic              cap_valid_i,
  input  logic [LEN_W-2:0]  cap_idx_i,
  input  logic [FD_W-1:0]   cap_data_i,
  input  logic              finish_i,
  output logic              start_o,
  output logic [FA_W-1:0]   start_haddr_o,
  output logic [LEN_W-1:0]  start_len_o,
  output logic [TIM_W-1:0]  adj_o,
  output logic [TIM_W-1:0]  str_o
);
  localparam int RIDX_W = BUS_AW - 2;
  localparam int WORDS  = (2 ** LEN_W) / 4;
  localparam int IDX_W  = LEN_W - 1;
  localparam int HALF_W = FD_W / 2;

  logic [RIDX_W-1:0] rd_idx;
  logic              unused_lsb;
  logic              ctrl_wr, ctrl_en, cfg_en, tail_drop;
  logic [REG_W-1:0]  ctrl_q, ctrl_d, cfg_q;
  logic              done_q, done_d;
  logic [LEN_W-1:0]  len_q;
  logic [REG_W-1:0]  data_w [WORDS];

  assign rd_idx     = bus_addr_i[BUS_AW-1:2];
  assign unused_lsb = ^bus_addr_i[1:0];
  assign ctrl_wr    = bus_wr_i && (rd_idx == RIDX_W'(IDX_CTRL)) && !busy_i;
  assign start_o    = ctrl_wr && bus_wdata_i[CTL_RD];
  assign cfg_en     = bus_wr_i && (rd_idx == RIDX_W'(IDX_CFG));
  assign ctrl_en    = ctrl_wr || finish_i;
  assign len_q      = ctrl_q[CTL_LEN_LSB +: LEN_W];
  assign tail_drop  = !len_q[0] && (cap_idx_i == len_q[LEN_W-1:1]);

  assign start_haddr_o = bus_wdata_i[CTL_ADR_LSB+1 +: FA_W];
  assign start_len_o   = bus_wdata_i[CTL_LEN_LSB +: LEN_W];
  assign adj_o         = cfg_q[CFG_ADJ_LSB +: TIM_W];
  assign str_o         = cfg_q[CFG_STR_LSB +: TIM_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata_i & CTL_KEEP;
    else if (finish_i) ctrl_d[CTL_RD] = 1'b0;
    done_d = done_q;
    if (start_o) done_d = 1'b0;
    else if (finish_i) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cfg_en)  cfg_q  <= bus_wdata_i & CFG_KEEP;
      done_q <= done_d;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [REG_W-1:0] word_q, word_d;
    logic             word_en;
    always_comb begin
      word_en = start_o || (cap_valid_i && (cap_idx_i[IDX_W-1:1] == (IDX_W-1)'(w)));
      word_d  = word_q;
      if (start_o) begin
        word_d = '0;
      end else if (!cap_idx_i[0]) begin
        word_d[HALF_W-1:0] = cap_data_i[HALF_W-1:0];
        if (!tail_drop) word_d[FD_W-1:HALF_W] = cap_data_i[FD_W-1:HALF_W];
      end else begin
        word_d[FD_W+HALF_W-1:FD_W] = cap_data_i[HALF_W-1:0];
        if (!tail_drop) word_d[2*FD_W-1:FD_W+HALF_W] = cap_data_i[FD_W-1:HALF_W];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (word_en) word_q <= word_d;
    end
    assign data_w[w] = word_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_idx == RIDX_W'(IDX_CTRL)) bus_rdata_o = ctrl_q;
    else if (rd_idx == RIDX_W'(IDX_CFG)) bus_rdata_o = cfg_q;
    else if (rd_idx == RIDX_W'(IDX_STAT)) bus_rdata_o[0] = done_q;
    for (int w = 0; w < WORDS; w++) begin
      if (int'(rd_idx) == IDX_DATA0 + w) bus_rdata_o = data_w[w];
    end
  end

  // R9
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(ctrl_q));
  // R8
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> (done_q && !ctrl_q[CTL_RD]));
  // R3
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> (!done_q && ctrl_q[CTL_RD]));
endmodule

// File: rtl/efuse_rd_seq.sv
`timescale 1ns/1ps
module efuse_rd_seq import efr_pkg::*; #(
  parameter int BUS_AW = 6,
  parameter int FA_W   = 9,
  parameter int FD_W   = 16,
  parameter int LEN_W  = 5,
  parameter int TIM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [FA_W-1:0]   fuse_addr,
  output logic              fuse_strobe,
  input  logic [FD_W-1:0]   fuse_rdata
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             start, busy, cap_valid, finish;
  logic [FA_W-1:0]  start_haddr;
  logic [LEN_W-1:0] start_len;
  logic [LEN_W-2:0] cap_idx;
  logic [FD_W-1:0]  cap_data;
  logic [TIM_W-1:0] adj, str;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  efr_regs #(.BUS_AW(BUS_AW), .FA_W(FA_W), .FD_W(FD_W), .LEN_W(LEN_W), .TIM_W(TIM_W)) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .busy_i(busy), .cap_valid_i(cap_valid), .cap_idx_i(cap_idx), .cap_data_i(cap_data),
    .finish_i(finish), .start_o(start), .start_haddr_o(start_haddr), .start_len_o(start_len),
    .adj_o(adj), .str_o(str));

  efr_seq #(.FA_W(FA_W), .FD_W(FD_W), .LEN_W(LEN_W), .TIM_W(TIM_W)) seq_i (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(start), .start_haddr_i(start_haddr), .start_len_i(start_len),
    .adj_i(adj), .str_i(str), .fuse_rdata_i(fuse_rdata),
    .fuse_addr_o(fuse_addr), .fuse_strobe_o(fuse_strobe), .busy_o(busy),
    .cap_valid_o(cap_valid), .cap_idx_o(cap_idx), .cap_data_o(cap_data), .finish_o(finish));
endmodule

// File: tb/efuse_rd_seq_tb_top.sv
`timescale 1ns/1ps
module efuse_rd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  fuse_addr;
  logic        fuse_strobe;
  logic [15:0] fuse_rdata;

  int  checks = 0;
  int  failures = 0;
  bit  run_chk = 1'b0;
  bit  last_pop = 1'b0;
  bit  ended = 1'b0;
  int  exp_q[$];
  int  m_adj = 0, m_str = 0, m_start = 0, m_len = 0;
  logic [31:0] m_ctrl = '0;

  always #5 clk = ~clk;

  function automatic logic [7:0] fb(int i);
    return 8'((i * 73 + 29) & 255);
  endfunction

  assign fuse_rdata = {fb(int'(fuse_addr) * 2 + 1), fb(int'(fuse_addr) * 2)};

  efuse_rd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe), .fuse_rdata(fuse_rdata));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // per-cycle reference comparison of the fuse interface
  always @(negedge clk) begin
    if (run_chk) begin
      if (exp_q.size() != 0) begin
        int e;
        e = exp_q.pop_front();
        last_pop = 1'b1;
        chk(fuse_strobe == e[9], "R4/R5 strobe schedule", 32'(fuse_strobe), 32'(e[9]));
        chk(fuse_addr == e[8:0], "R6 address", 32'(fuse_addr), 32'(e[8:0]));
      end else begin
        last_pop = 1'b0;
        chk(fuse_strobe == 1'b0, "R10 idle strobe", 32'(fuse_strobe), 32'd0);
      end
    end
  end

  task automatic push_sched(int sbyte, int len);
    for (int j = 0; j <= len / 2; j++) begin
      int a;
      a = ((sbyte >> 1) + j) % 512;
      for (int c = 0; c < m_adj + 1; c++) exp_q.push_back(a);
      for (int c = 0; c < m_str + 4; c++) exp_q.push_back(512 | a);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    bit busy_now;
    @(negedge clk);
    bus_addr = 6'(a); bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    busy_now = last_pop || (exp_q.size() != 0);
    if ((a >> 2) == 0 && !busy_now) begin
      m_ctrl = d & 32'h7FFF_8003;
      if (d[0]) begin
        m_start = int'(d[30:21]);
        m_len   = int'(d[20:16]);
        push_sched(m_start, m_len);
      end
    end
    if ((a >> 2) == 1) begin
      m_adj = int'(d[23:20]);
      m_str = int'(d[19:16]);
    end
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req);
    logic [31:0] v;
    bus_read(a, v);
    chk(v === exp, req, v, exp);
  endtask

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      int k;
      k = 4 * w + b;
      if (k <= m_len) r[8*b +: 8] = fb(2 * (((m_start >> 1) + k / 2) % 512) + k % 2);
    end
    return r;
  endfunction

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (last_pop || exp_q.size() != 0);
  endtask

  task automatic check_burst();
    wait_idle();
    m_ctrl[0] = 1'b0;
    rd_chk(8'h00, m_ctrl, "R8 ctrl after burst");
    rd_chk(8'h08, 32'h1, "R8 done set");
    for (int w = 0; w < 8; w++) rd_chk(12 + 4 * w, exp_word(w), "R7 packed data");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_chk = 1'b1;
    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1 ctrl");
    rd_chk(8'h04, 32'h0, "R1 cfg");
    rd_chk(8'h08, 32'h0, "R1 status");
    rd_chk(8'h0C, 32'h0, "R1 data0");
    chk(fuse_addr == 9'd0, "R1 fuse_addr", 32'(fuse_addr), 32'd0);

    // R2 field masks, unmapped space
    bus_write(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h80FF_FFFF, "R2 cfg mask");
    bus_write(8'h00, 32'hFFFF_FFFE);
    rd_chk(8'h00, 32'h7FFF_8002, "R2 ctrl mask");
    repeat (30) @(negedge clk);
    rd_chk(8'h08, 32'h0, "R10 no burst without read enable");
    rd_chk(8'h2C, 32'h0, "R2 unmapped 0x2C");
    rd_chk(8'h3C, 32'h0, "R2 unmapped 0x3C");

    // burst A: full 32 bytes, fastest timing
    bus_write(8'h04, 32'h0000_0000);
    bus_write(8'h00, (32'd0 << 21) | (32'd31 << 16) | 32'h1);
    rd_chk(8'h08, 32'h0, "R3 done clear while busy");
    rd_chk(8'h00, m_ctrl, "R3 read enable held");
    check_burst();

    // burst B: 7 bytes, other timing, garbage in unused cfg fields
    bus_write(8'h04, 32'h8023_5ABC);
    bus_write(8'h00, (32'd100 << 21) | (32'd6 << 16) | 32'h1);
    rd_chk(8'h08, 32'h0, "R3 done cleared at start");
    rd_chk(8'h28, 32'h0, "R3 data cleared at start");
    bus_write(8'h00, (32'd700 << 21) | (32'd2 << 16) | 32'h1);
    check_burst();

    // burst C: wrap past top of array
    bus_write(8'h04, 32'h0011_0000);
    bus_write(8'h00, (32'd1022 << 21) | (32'd31 << 16) | 32'h1);
    check_burst();

    // burst D: odd start, single byte, slowest timing, program/write bits set (R10)
    bus_write(8'h04, 32'h00FF_0000);
    bus_write(8'h00, (32'd37 << 21) | (32'd0 << 16) | 32'h8003);
    check_burst();

    // same-cycle collision: restart lands on completing edge (R9)
    bus_write(8'h04, 32'h0000_0000);
    bus_write(8'h00, (32'd200 << 21) | (32'd3 << 16) | 32'h1);
    do begin @(posedge clk); #1; end while (exp_q.size() != 1);
    bus_write(8'h00, (32'd500 << 21) | (32'd31 << 16) | 32'h1);
    check_burst();
    repeat (30) @(negedge clk);
    rd_chk(8'h00, m_ctrl, "R9 collision write dropped");

    // R9 status and data writes ignored
    bus_write(8'h08, 32'h0);
    bus_write(8'h0C, 32'hDEAD_BEEF);
    rd_chk(8'h08, 32'h1, "R9 status write ignored");
    rd_chk(8'h0C, exp_word(0), "R9 data write ignored");

    run_chk = 1'b0;
    summary();
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule